// File: doc/BRIEF.md
# Two-Wire Register Access Target with Pointer Auto-Increment

This block lets a two-wire (I2C) bus host read and write a byte-wide register file inside the chip. The host addresses the target with a 7-bit device address and a direction bit. In a write, the first byte after the address loads an internal register pointer, and every later byte is stored at the pointer. The top bit of the pointer byte is not an address bit. It selects whether the pointer steps forward after each data byte or stays where it is.

A read transaction has no pointer phase. To read a chosen register, the host first issues a short write that carries only the pointer byte and ends it with a stop or a repeated start. It then opens a read, and the target returns bytes from the pointer onward until the host refuses a byte. The block samples SCL and SDA in the system clock domain through synchronizers. It pulls SDA low through an open-drain enable and talks to the register file through a plain address, write-data, write-strobe and read-data port.

Top module: `regbus_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h40), by pulling SDA low during the ninth SCL high phase. With any other address it never pulls SDA low, performs no register write, and ignores every byte until the next start condition.
- R2: The eighth bit of the address byte selects the direction: 0 opens a write (a pointer byte follows) and 1 opens a read (the target transmits).
- R3: In a write, the first byte after the address is acknowledged. Its bits 6:0 load the 7-bit pointer, and its bit 7 sets the increment mode.
- R4: Every data byte after the pointer byte is acknowledged and produces exactly one single-cycle reg_we pulse, with reg_addr equal to the current pointer and reg_wdata equal to the byte.
- R5: With increment mode 1, the pointer advances by one after every data byte transferred, in either direction. With mode 0 it stays unchanged, so repeated bytes go to, or come from, the same register.
- R6: An advancing pointer wraps from 7'h7F to 7'h00.
- R7: The pointer and the increment mode keep their values across stop and start conditions. A read therefore begins at the pointer loaded by an earlier write.
- R8: In a read, the target drives each byte MSB first. It keeps transmitting after each host acknowledge, and it releases SDA and stops after the first byte the host does not acknowledge.
- R9: A repeated start is treated exactly like a start. A stop at any point, including in the middle of a byte, returns the target to idle with SDA released.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released, reg_we is low, the pointer is 0 and increment mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen at the pin |
| sda_in | input | 1 | SDA level seen at the pin (resolved bus) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | PTR_W (7) | Register file address, equal to the pointer |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at reg_addr |

## Verification
The bench writes all 128 registers in one burst that starts near the top of the map, so a pointer without wrap-around would overwrite the low registers or skip them. It then reads the whole map back in one read, which would show a pointer that forgot its value across the stop or stepped at the wrong time. Fixed-pointer bursts in both directions catch a design that ignores bit 7 of the pointer byte or treats it as an address bit. Wrong-address transactions, a repeated start without a stop, and a stop cut into the middle of a byte catch a target that acknowledges strangers, writes while it should be ignoring the bus, or stays stuck in a half-received byte.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDATA,
        PH_ACK,
        PH_TX,
        PH_TXACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        phase_e              after;
        logic [CNT_W-1:0]    bits;
        logic [BYTE_W-1:0]   shreg;
        logic                sda_oe;
        logic                we;
        logic [BYTE_W-1:0]   wdata;
    } fsm_s;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q[i] <= 1'b1;
                    sda_pipe_q[i] <= 1'b1;
                end else begin
                    scl_pipe_q[i] <= scl_in;
                    sda_pipe_q[i] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe_q[i] <= 1'b1;
                    sda_pipe_q[i] <= 1'b1;
                end else begin
                    scl_pipe_q[i] <= scl_pipe_q[i-1];
                    sda_pipe_q[i] <= sda_pipe_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_o     = scl_pipe_q[STAGES-1];
    assign sda_o     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_o & ~scl_prev_q;
    assign scl_fall  = ~scl_o & scl_prev_q;
    assign start_det = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_det  = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             load_incr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic             incr
);

    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic             incr_d, incr_q;

    always_comb begin
        ptr_d  = ptr_q;
        incr_d = incr_q;
        if (load) begin
            ptr_d  = load_ptr;
            incr_d = load_incr;
        end else if (step && incr_q) begin
            ptr_d = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            incr_q <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            incr_q <= incr_d;
        end
    end

    assign ptr  = ptr_q;
    assign incr = incr_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && incr_q && !load && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0)); // R6
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && incr_q && !load) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(step && incr_q)) |=> ($stable(ptr_q) && $stable(incr_q))); // R7

endmodule

// File: rtl/regbus_i2c_target.sv
module regbus_i2c_target
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h40,
    parameter int         PTR_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] BIT_ONE   = CNT_W'(1);

    fsm_s q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ptr_load, ptr_step, ptr_incr;
    logic [PTR_W-1:0] ptr;
    logic addr_hit;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_ptr  (q.shreg[PTR_W-1:0]),
        .load_incr (q.shreg[BYTE_W-1]),
        .step      (ptr_step),
        .ptr       (ptr),
        .incr      (ptr_incr)
    );

    assign addr_hit = (q.shreg[BYTE_W-1:1] == DEV_ADDR);

    always_comb begin
        n        = q;
        n.we     = 1'b0;
        ptr_load = 1'b0;
        ptr_step = q.we;
        if (stop_det) begin
            n.phase  = PH_IDLE;
            n.sda_oe = 1'b0;
            n.bits   = '0;
        end else if (start_det) begin
            n.phase  = PH_ADDR;
            n.sda_oe = 1'b0;
            n.bits   = '0;
        end else begin
            unique case (q.phase)
                PH_ADDR, PH_PTR, PH_WDATA: begin
                    if (scl_rise && q.bits != BITS_FULL) begin
                        n.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        n.bits  = q.bits + BIT_ONE;
                    end else if (scl_fall && q.bits == BITS_FULL) begin
                        n.bits   = '0;
                        n.sda_oe = 1'b1;
                        n.phase  = PH_ACK;
                        if (q.phase == PH_ADDR) begin
                            if (addr_hit) begin
                                n.after = q.shreg[0] ? PH_TX : PH_PTR;
                            end else begin
                                n.phase  = PH_SKIP;
                                n.sda_oe = 1'b0;
                            end
                        end else if (q.phase == PH_PTR) begin
                            ptr_load = 1'b1;
                            n.after  = PH_WDATA;
                        end else begin
                            n.we    = 1'b1;
                            n.wdata = q.shreg;
                            n.after = PH_WDATA;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        n.phase  = q.after;
                        n.bits   = '0;
                        n.sda_oe = 1'b0;
                        if (q.after == PH_TX) begin
                            n.shreg  = reg_rdata;
                            n.sda_oe = ~reg_rdata[BYTE_W-1];
                            n.bits   = BIT_ONE;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bits == BITS_FULL) begin
                            n.sda_oe = 1'b0;
                            n.phase  = PH_TXACK;
                            ptr_step = 1'b1;
                        end else begin
                            n.sda_oe = ~q.shreg[BYTE_W-2];
                            n.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            n.bits   = q.bits + BIT_ONE;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            n.phase = PH_SKIP;
                        end else begin
                            n.phase = PH_ACK;
                            n.after = PH_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase  <= PH_IDLE;
            q.after  <= PH_IDLE;
            q.bits   <= '0;
            q.shreg  <= '0;
            q.sda_oe <= 1'b0;
            q.we     <= 1'b0;
            q.wdata  <= '0;
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.sda_oe;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
    assign reg_addr  = ptr;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_oe) |-> !scl_s); // R10
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R4
    AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe); // R4
    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE || q.phase == PH_SKIP) |-> !sda_oe); // R9
    AST_NO_WRITE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SKIP) |-> !reg_we); // R1
    AST_INCR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load) |=> $stable(ptr_incr)); // R7

endmodule

// File: tb/sim_regbus_i2c_target.sv
module sim_regbus_i2c_target;

    localparam int Q = 5;
    localparam logic [6:0] DEV = 7'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;

    logic [7:0] mem [128];
    logic [7:0] exp_mem [128];
    int wr_count = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign sda_line  = sda_h & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    regbus_i2c_target #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_count      <= wr_count + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        sda_h = b; tick(Q);
        scl_h = 1'b1; tick(2 * Q);
        scl_h = 1'b0; tick(Q);
    endtask

    // ack = SDA low in ninth slot; held = low for the whole high phase
    task automatic send_byte(logic [7:0] v, output logic ack, output logic held);
        logic early;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(1);
        early = ~sda_line;
        tick(Q - 1);
        ack = ~sda_line;
        tick(Q - 1);
        held = early & ack & ~sda_line;
        tick(1);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic host_ack);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_h = 1'b1; tick(Q);
            v[i] = sda_line;
            tick(Q);
            scl_h = 1'b0;
        end
        tick(Q);
        sda_h = ~host_ack; tick(Q);
        scl_h = 1'b1; tick(2 * Q);
        scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    task automatic set_ptr(logic [7:0] pb, logic do_stop);
        logic a, h;
        bus_start();
        send_byte({DEV, 1'b0}, a, h);
        chk("R2 write address acked", a, 1);
        send_byte(pb, a, h);
        chk("R3 pointer byte acked", a, 1);
        if (do_stop) bus_stop();
    endtask

    initial begin
        logic a, h;
        logic [7:0] v;
        int wc;
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R11: reset state
        chk("R11 sda released after reset", sda_oe, 0);
        chk("R11 no write strobe after reset", reg_we, 0);
        chk("R11 pointer zero after reset", reg_addr, 0);
        bus_start();
        send_byte({DEV, 1'b1}, a, h);
        chk("R1 read address acked", a, 1);
        recv_byte(v, 1'b0);
        bus_stop();
        chk("R11 first read from register 0", v, 0);

        // R6/R5/R4: 128-byte incrementing burst from 0x70, wraps past 0x7F
        wc = wr_count;
        set_ptr(8'h80 | 8'h70, 1'b0);
        for (int i = 0; i < 128; i++) begin
            send_byte(pat(i), a, h);
            chk("R4 data byte acked", a, 1);
            chk("R10 ack held through SCL high", h, 1);
            exp_mem[(8'h70 + i) & 8'h7F] = pat(i);
        end
        bus_stop();
        tick(2);
        chk("R4 one strobe per data byte", wr_count - wc, 128);
        chk("R9 sda released after stop", sda_oe, 0);
        for (int i = 0; i < 128; i++) chk("R6 wrapped burst contents", mem[i], exp_mem[i]);

        // R7/R8: load pointer, stop, read whole map with incrementing pointer
        set_ptr(8'h80 | 8'h00, 1'b1);
        bus_start();
        send_byte({DEV, 1'b1}, a, h);
        chk("R2 read direction acked", a, 1);
        for (int i = 0; i < 128; i++) begin
            recv_byte(v, (i != 127));
            chk("R8 read data MSB first", v, exp_mem[i]);
        end
        bus_stop();
        tick(2);
        chk("R8 sda released after host nack", sda_oe, 0);

        // R5: fixed pointer, write then read
        wc = wr_count;
        set_ptr(8'h15, 1'b0);
        send_byte(8'hA1, a, h); chk("R4 fixed write acked", a, 1);
        send_byte(8'hB2, a, h); chk("R4 fixed write acked", a, 1);
        send_byte(8'hC3, a, h); chk("R4 fixed write acked", a, 1);
        bus_stop();
        tick(2);
        exp_mem[8'h15] = 8'hC3;
        chk("R5 fixed pointer strobes", wr_count - wc, 3);
        chk("R5 fixed pointer last value", mem[8'h15], 8'hC3);
        chk("R5 neighbour untouched", mem[8'h16], exp_mem[8'h16]);
        bus_start();
        send_byte({DEV, 1'b1}, a, h);
        chk("R7 read after stop acked", a, 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(v, (i != 2));
            chk("R5 fixed pointer read repeats", v, 8'hC3);
        end
        bus_stop();

        // R1: wrong addresses
        wc = wr_count;
        bus_start();
        send_byte({7'h41, 1'b0}, a, h);
        chk("R1 foreign write address not acked", a, 0);
        send_byte(8'h80 | 8'h20, a, h);
        chk("R1 ignored pointer byte not acked", a, 0);
        send_byte(8'h99, a, h);
        chk("R1 ignored data byte not acked", a, 0);
        bus_stop();
        bus_start();
        send_byte({7'h00, 1'b1}, a, h);
        chk("R1 foreign read address not acked", a, 0);
        recv_byte(v, 1'b0);
        chk("R1 no data driven when ignoring", v, 8'hFF);
        bus_stop();
        tick(2);
        chk("R1 no write while ignoring", wr_count - wc, 0);
        chk("R1 register unchanged", mem[8'h20], exp_mem[8'h20]);

        // R9/R6: repeated start, read across the wrap
        set_ptr(8'h80 | 8'h7E, 1'b0);
        bus_start();
        send_byte({DEV, 1'b1}, a, h);
        chk("R9 repeated start read acked", a, 1);
        recv_byte(v, 1'b1); chk("R9 repeated start data", v, exp_mem[8'h7E]);
        recv_byte(v, 1'b1); chk("R6 read at top", v, exp_mem[8'h7F]);
        recv_byte(v, 1'b0); chk("R6 read wraps to 0", v, exp_mem[8'h00]);
        bus_stop();

        // R9: stop inside a byte, then a normal write
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        tick(2);
        chk("R9 released after mid-byte stop", sda_oe, 0);
        set_ptr(8'h30, 1'b0);
        send_byte(8'h5A, a, h);
        chk("R9 write after mid-byte stop acked", a, 1);
        bus_stop();
        tick(2);
        chk("R9 write after mid-byte stop stored", mem[8'h30], 8'h5A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule